// File: doc/BRIEF.md
# HDLC Transmit Frame Closer

This block sits on the transmit side of a bit-oriented synchronous serial channel. Characters arrive from the CPU or from a DMA engine into a small transmit buffer. A one-symbol output register then presents them to a downstream serializer, which applies bit stuffing and clocking. The block opens each frame with a flag and passes the characters through in order. It also decides when and how the frame closes.

A frame closes for one of three reasons. The first is an explicit end-of-message command, which marks the next character written as the final one. The second is a character tagged as the end of a chained DMA block. The third is a buffer underrun, which occurs when a data character leaves the output register while the buffer is empty and no end-of-message is pending. A normal close requests the frame check sequence from an external CRC unit and sends it complemented, low byte first, followed by a flag. When a control bit is set, an underrun produces an abort byte instead. Either way the transmitter then returns to sending idle flags.

An underrun also sets a sticky status bit, which can raise an interrupt. While that bit is set, the transmit-ready status stays low. This stops a DMA engine from pushing the rest of a broken frame as if it were a new one.

Top module: `hdlc_tx_closer`

## Requirements
- R1: After reset the block presents a valid flag symbol (kind 0, byte 0x7E), with fcs_req, udr_sts and irq low and tx_rdy high.
- R2: While the buffer is empty and no frame is open, every symbol presented is a flag. A frame starts with one flag, followed by the buffered characters as kind 1 symbols in the order they were written.
- R3: After an eom_cmd pulse, the next character accepted into the buffer is the last data symbol of its frame.
- R4: A character written with wr_last high is the last data symbol of its frame.
- R5: If an end-of-message command is pending when the last data symbol leaves and the buffer is empty, the frame closes normally and no underrun is flagged.
- R6: On a normal close, sym_vld drops and fcs_req stays high until fcs_valid is seen. Two kind 2 symbols then follow: the complement of fcs_value[7:0], then the complement of fcs_value[15:8]. After them comes a flag.
- R7: With abort_on_udr low, an underrun closes the frame exactly as in R6.
- R8: With abort_on_udr high, an underrun sends one kind 3 symbol (byte 0xFF) followed by flags, and fcs_req is never raised for that frame.
- R9: An underrun sets udr_sts, which holds until a udr_clr pulse. While udr_sts is high, tx_rdy is low even if the buffer is empty.
- R10: irq equals udr_sts gated by irq_en.
- R11: When the buffer holds DEPTH characters, tx_rdy is low and a further write is dropped: it never appears in the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write a character into the transmit buffer |
| wr_data | input | 8 | Character to write |
| wr_last | input | 1 | Character ends a chained DMA block |
| eom_cmd | input | 1 | End-of-message command pulse |
| abort_on_udr | input | 1 | Underrun sends an abort instead of a normal close |
| irq_en | input | 1 | Underrun interrupt enable |
| udr_clr | input | 1 | Write-one-to-clear for the underrun status |
| ser_take | input | 1 | Serializer consumes the presented symbol |
| fcs_valid | input | 1 | External CRC value is ready |
| fcs_value | input | 16 | External CRC register value, uncomplemented |
| sym_vld | output | 1 | A symbol is presented |
| sym_kind | output | 2 | 0 flag, 1 data, 2 FCS, 3 abort |
| sym_data | output | 8 | Symbol byte |
| fcs_req | output | 1 | Request for the frame check value |
| tx_rdy | output | 1 | Buffer has room and no underrun is pending |
| udr_sts | output | 1 | Sticky underrun status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH = 4. With a buffer that shallow, a paused serializer fills it within four writes, so the full-buffer drop and tx_rdy holdoff are easy to reach. A writer that simply stops after a few characters produces an underrun at a known symbol. The serializer model takes symbols with random gaps and the CRC responder answers with random delay. Together they shift every close decision across different cycle alignments of buffer occupancy, the pending end-of-message command and the CRC handshake.

// File: rtl/hdlc_txc_pkg.sv
package hdlc_txc_pkg;

    typedef enum logic [1:0] {
        SYM_FLAG  = 2'd0,
        SYM_DATA  = 2'd1,
        SYM_FCS   = 2'd2,
        SYM_ABORT = 2'd3
    } sym_kind_e;

    localparam logic [7:0] FLAG_BYTE  = 8'h7E;
    localparam logic [7:0] ABORT_BYTE = 8'hFF;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } buf_ent_t;

    typedef struct packed {
        logic       vld;
        sym_kind_e  kind;
        logic [7:0] data;
    } sym_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_FCSW,
        ST_FCS1,
        ST_FCS2,
        ST_ABORT
    } fr_state_e;

    function automatic sym_t mk_sym(sym_kind_e k, logic [7:0] d);
        sym_t s;
        s.vld  = 1'b1;
        s.kind = k;
        s.data = d;
        return s;
    endfunction

    function automatic sym_t no_sym();
        sym_t s;
        s.vld  = 1'b0;
        s.kind = SYM_FLAG;
        s.data = 8'h00;
        return s;
    endfunction

endpackage

// File: rtl/txc_buf.sv
module txc_buf
    import hdlc_txc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  buf_ent_t wr_ent,
    input  logic     pop,
    output buf_ent_t head,
    output logic     empty,
    output logic     full
);
    localparam int AW    = $clog2(DEPTH);
    localparam int PTR_W = AW + 1;

    buf_ent_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] count;

    assign count = wr_ptr - rd_ptr;
    assign empty = (count == '0);
    assign full  = (count == PTR_W'(DEPTH));
    assign head  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= wr_ent;
    end

    // R11
    buf_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= PTR_W'(DEPTH));

    // R2
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/txc_udr.sv
module txc_udr (
    input  logic clk,
    input  logic rst,
    input  logic udr_set,
    input  logic udr_clr,
    input  logic irq_en,
    output logic udr_sts,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)           udr_sts <= 1'b0;
        else if (udr_set)  udr_sts <= 1'b1;
        else if (udr_clr)  udr_sts <= 1'b0;
    end

    assign irq = udr_sts & irq_en;

    // R9
    udr_set_chk: assert property (@(posedge clk) disable iff (rst)
        udr_set |=> udr_sts);

    // R9
    udr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (udr_clr && !udr_set) |=> !udr_sts);

    // R9
    udr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (udr_sts && !udr_clr) |=> udr_sts);

endmodule

// File: rtl/txc_seq.sv
module txc_seq
    import hdlc_txc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  buf_ent_t    head,
    input  logic        buf_empty,
    input  logic        wr_acc,
    input  logic        eom_cmd,
    input  logic        abort_on_udr,
    input  logic        ser_take,
    input  logic        fcs_valid,
    input  logic [15:0] fcs_value,
    output logic        pop,
    output logic        tag_last,
    output logic        udr_evt,
    output sym_t        sym,
    output logic        fcs_req
);
    fr_state_e  state, nxt_state;
    sym_t       nxt_sym;
    logic       cur_last, nxt_last;
    logic [7:0] fcs_hi, nxt_hi;
    logic       eom_pend, eom_close;

    assign tag_last = eom_pend;
    assign fcs_req  = (state == ST_FCSW);

    always_comb begin
        nxt_state = state;
        nxt_sym   = sym;
        nxt_last  = cur_last;
        nxt_hi    = fcs_hi;
        pop       = 1'b0;
        udr_evt   = 1'b0;
        eom_close = 1'b0;
        case (state)
            ST_IDLE: if (ser_take) begin
                nxt_sym = mk_sym(SYM_FLAG, FLAG_BYTE);
                if (!buf_empty) nxt_state = ST_OPEN;
            end
            ST_OPEN, ST_DATA: if (ser_take) begin
                if (state == ST_DATA && cur_last) begin
                    nxt_sym   = no_sym();
                    nxt_state = ST_FCSW;
                end else if (!buf_empty) begin
                    pop       = 1'b1;
                    nxt_sym   = mk_sym(SYM_DATA, head.data);
                    nxt_last  = head.last;
                    nxt_state = ST_DATA;
                end else if (eom_pend) begin
                    eom_close = 1'b1;
                    nxt_sym   = no_sym();
                    nxt_state = ST_FCSW;
                end else begin
                    udr_evt = 1'b1;
                    if (abort_on_udr) begin
                        nxt_sym   = mk_sym(SYM_ABORT, ABORT_BYTE);
                        nxt_state = ST_ABORT;
                    end else begin
                        nxt_sym   = no_sym();
                        nxt_state = ST_FCSW;
                    end
                end
            end
            ST_FCSW: if (fcs_valid) begin
                nxt_sym   = mk_sym(SYM_FCS, ~fcs_value[7:0]);
                nxt_hi    = ~fcs_value[15:8];
                nxt_state = ST_FCS1;
            end
            ST_FCS1: if (ser_take) begin
                nxt_sym   = mk_sym(SYM_FCS, fcs_hi);
                nxt_state = ST_FCS2;
            end
            ST_FCS2, ST_ABORT: if (ser_take) begin
                nxt_sym   = mk_sym(SYM_FLAG, FLAG_BYTE);
                nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sym      <= mk_sym(SYM_FLAG, FLAG_BYTE);
            cur_last <= 1'b0;
            fcs_hi   <= 8'h00;
            eom_pend <= 1'b0;
        end else begin
            state    <= nxt_state;
            sym      <= nxt_sym;
            cur_last <= nxt_last;
            fcs_hi   <= nxt_hi;
            if (eom_cmd)                  eom_pend <= 1'b1;
            else if (wr_acc || eom_close) eom_pend <= 1'b0;
        end
    end

    // R6
    fcs_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (fcs_req && fcs_valid) |=>
            (sym.vld && sym.kind == SYM_FCS && sym.data == ~$past(fcs_value[7:0])));

    // R6
    close_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FCS2 && ser_take) |=> (sym.vld && sym.kind == SYM_FLAG));

    // R8
    abort_then_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (sym.vld && sym.kind == SYM_ABORT && ser_take) |=>
            (sym.vld && sym.kind == SYM_FLAG && !fcs_req));

endmodule

// File: rtl/hdlc_tx_closer.sv
module hdlc_tx_closer
    import hdlc_txc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        wr_last,
    input  logic        eom_cmd,
    input  logic        abort_on_udr,
    input  logic        irq_en,
    input  logic        udr_clr,
    input  logic        ser_take,
    input  logic        fcs_valid,
    input  logic [15:0] fcs_value,
    output logic        sym_vld,
    output logic [1:0]  sym_kind,
    output logic [7:0]  sym_data,
    output logic        fcs_req,
    output logic        tx_rdy,
    output logic        udr_sts,
    output logic        irq
);
    buf_ent_t wr_ent, head;
    logic     push, pop, buf_empty, buf_full;
    logic     tag_last, udr_evt;
    sym_t     sym;

    assign push        = wr_valid && !buf_full;
    assign wr_ent.data = wr_data;
    assign wr_ent.last = wr_last | tag_last;

    txc_buf #(.DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .push   (push),
        .wr_ent (wr_ent),
        .pop    (pop),
        .head   (head),
        .empty  (buf_empty),
        .full   (buf_full)
    );

    txc_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .head         (head),
        .buf_empty    (buf_empty),
        .wr_acc       (push),
        .eom_cmd      (eom_cmd),
        .abort_on_udr (abort_on_udr),
        .ser_take     (ser_take),
        .fcs_valid    (fcs_valid),
        .fcs_value    (fcs_value),
        .pop          (pop),
        .tag_last     (tag_last),
        .udr_evt      (udr_evt),
        .sym          (sym),
        .fcs_req      (fcs_req)
    );

    txc_udr u_udr (
        .clk     (clk),
        .rst     (rst),
        .udr_set (udr_evt),
        .udr_clr (udr_clr),
        .irq_en  (irq_en),
        .udr_sts (udr_sts),
        .irq     (irq)
    );

    assign tx_rdy   = !buf_full && !udr_sts;
    assign sym_vld  = sym.vld;
    assign sym_kind = sym.kind;
    assign sym_data = sym.data;

    // R9
    rdy_udr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(udr_sts) |-> !tx_rdy);

endmodule

// File: tb/tb_hdlc_tx_closer.sv
module tb_hdlc_tx_closer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0, wr_last = 1'b0, eom_cmd = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        abort_on_udr = 1'b0, irq_en = 1'b0, udr_clr = 1'b0;
    logic        ser_take = 1'b0, fcs_valid = 1'b0;
    logic [15:0] fcs_value = 16'h0000;
    logic        sym_vld, fcs_req, tx_rdy, udr_sts, irq;
    logic [1:0]  sym_kind;
    logic [7:0]  sym_data;

    hdlc_tx_closer #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_last(wr_last), .eom_cmd(eom_cmd), .abort_on_udr(abort_on_udr),
        .irq_en(irq_en), .udr_clr(udr_clr), .ser_take(ser_take),
        .fcs_valid(fcs_valid), .fcs_value(fcs_value), .sym_vld(sym_vld),
        .sym_kind(sym_kind), .sym_data(sym_data), .fcs_req(fcs_req),
        .tx_rdy(tx_rdy), .udr_sts(udr_sts), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit ser_en = 0;
    int fcs_seen = 0;
    logic [15:0] cur_crc = 16'hFFFF;
    logic [9:0] act_q[$];
    logic [9:0] exp_q[$];
    bit last_flag = 0;

    function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [9:0] tok(logic [1:0] k, logic [7:0] d);
        return {k, d};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Serializer model: records each consumed symbol, collapsing flag runs
    initial begin
        int gap = 0;
        forever begin
            @(negedge clk);
            if (ser_take) begin
                ser_take = 1'b0;
                gap = $urandom_range(3, 1);
            end else if (gap > 0) begin
                gap--;
            end else if (ser_en && sym_vld && !rst) begin
                ser_take = 1'b1;
                if (sym_kind == 2'd0) begin
                    if (!last_flag) act_q.push_back(tok(sym_kind, sym_data));
                    last_flag = 1;
                end else begin
                    act_q.push_back(tok(sym_kind, sym_data));
                    last_flag = 0;
                end
            end
        end
    end

    // External CRC responder
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (fcs_req) fcs_seen++;
            if (fcs_valid) begin
                fcs_valid = 1'b0;
                dly = $urandom_range(3, 0);
            end else if (fcs_req && !rst) begin
                if (dly == 0) begin
                    fcs_valid = 1'b1;
                    fcs_value = cur_crc;
                end else dly--;
            end
        end
    end

    task automatic wr_byte(input logic [7:0] d, input bit last);
        while (!tx_rdy) @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_last = last;
        cur_crc = crc_upd(cur_crc, d);
        exp_q.push_back(tok(2'd1, d));
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    task automatic eom();
        eom_cmd = 1'b1;
        @(negedge clk);
        eom_cmd = 1'b0;
    endtask

    task automatic exp_close(input bit aborted);
        if (aborted) exp_q.push_back(tok(2'd3, 8'hFF));
        else begin
            exp_q.push_back(tok(2'd2, ~cur_crc[7:0]));
            exp_q.push_back(tok(2'd2, ~cur_crc[15:8]));
        end
        exp_q.push_back(tok(2'd0, 8'h7E));
    endtask

    task automatic compare(input string req);
        repeat (150) @(negedge clk);
        chk(act_q.size() == exp_q.size(), req, "symbol count", act_q.size(), exp_q.size());
        for (int i = 0; i < act_q.size() && i < exp_q.size(); i++)
            chk(act_q[i] == exp_q[i], req, $sformatf("symbol %0d", i), act_q[i], exp_q[i]);
        // R2: idle flags after the frame
        chk(sym_vld && sym_kind == 2'd0 && sym_data == 8'h7E, "R2", "idle symbol",
            {sym_vld, sym_kind, sym_data}, {1'b1, 2'd0, 8'h7E});
        act_q.delete();
        exp_q.delete();
    endtask

    task automatic check_udr(input bit exp_udr, input string req);
        chk(udr_sts == exp_udr, req, "udr_sts", udr_sts, exp_udr);
        chk(irq == (exp_udr && irq_en), "R10", "irq", irq, exp_udr && irq_en);
        chk(tx_rdy == !exp_udr, "R9", "tx_rdy under udr", tx_rdy, !exp_udr);
        if (udr_sts) begin
            udr_clr = 1'b1;
            @(negedge clk);
            udr_clr = 1'b0;
            chk(udr_sts == 1'b0, "R9", "udr_sts after clear", udr_sts, 0);
            chk(tx_rdy == 1'b1, "R9", "tx_rdy after clear", tx_rdy, 1);
            chk(irq == 1'b0, "R10", "irq after clear", irq, 0);
        end
    endtask

    // mode 0: DMA tag, 1: eom before last, 2: underrun, 3: eom after all
    task automatic run_frame(input int n, input int mode, input bit abrt,
                             input bit ien, input string req);
        abort_on_udr = abrt;
        irq_en = ien;
        cur_crc = 16'hFFFF;
        fcs_seen = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'($urandom);
            if (mode == 1 && i == n - 1) eom();
            wr_byte(d, (mode == 0 && i == n - 1));
        end
        if (mode == 3) eom();
        exp_close(mode == 2 && abrt);
        compare(req);
        if (mode == 2 && abrt)
            chk(fcs_seen == 0, "R8", "fcs_req cycles in abort frame", fcs_seen, 0);
        else
            chk(fcs_seen > 0, "R6", "fcs_req raised", fcs_seen, 1);
        check_udr(mode == 2, mode == 2 ? "R9" : "R5");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sym_vld && sym_kind == 2'd0 && sym_data == 8'h7E, "R1", "reset symbol",
            {sym_vld, sym_kind, sym_data}, {1'b1, 2'd0, 8'h7E});
        chk(!fcs_req && !udr_sts && !irq && tx_rdy, "R1", "reset status",
            {fcs_req, udr_sts, irq, tx_rdy}, 4'b0001);
        exp_q.push_back(tok(2'd0, 8'h7E));
        ser_en = 1;
        repeat (10) @(negedge clk);
        // R2 idle flags only
        chk(act_q.size() == 1, "R2", "idle flag run", act_q.size(), 1);

        run_frame(4, 1, 0, 1, "R3");   // R3 eom command
        run_frame(6, 0, 0, 1, "R4");   // R4 DMA tag
        run_frame(2, 3, 0, 1, "R5");   // R5 eom pending, buffer empty
        run_frame(3, 2, 0, 1, "R7");   // R7 underrun closes normally
        run_frame(3, 2, 1, 0, "R8");   // R8 underrun aborts, irq masked
        run_frame(1, 0, 0, 0, "R6");   // R6 single-character frame

        // R11 full buffer drops extra write
        ser_en = 0;
        repeat (6) @(negedge clk);
        cur_crc = 16'hFFFF;
        for (int i = 0; i < DEPTH; i++) wr_byte(8'h10 + 8'(i), i == DEPTH - 1);
        chk(tx_rdy == 1'b0, "R11", "tx_rdy when full", tx_rdy, 0);
        wr_valid = 1'b1; wr_data = 8'hAA;
        @(negedge clk);
        wr_valid = 1'b0;
        ser_en = 1;
        exp_close(0);
        compare("R11");

        for (int f = 0; f < 24; f++)
            run_frame($urandom_range(10, 1), $urandom_range(3, 0),
                      1'($urandom), 1'($urandom), "R2");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule